// File: doc/BRIEF.md
# Accumulator Processor Control-Line Decoder

This block is the control decoder of a small accumulator processor. It is purely combinational. Its inputs are the two cycle-phase levels (fetch and execute), the two write strobes that fire inside those phases, the 3-bit opcode held in the instruction register, and a flag that says the accumulator holds zero. From these it drives fifteen individual control wires into the datapath:

- the halt line;
- three ALU operation selects;
- three accumulator input selects;
- two memory address selects;
- the instruction-register, accumulator and memory write enables;
- the program-counter increment, load and write lines.

During fetch, the decoder points memory at the program counter, readies the increment, and commits the instruction register and the incremented PC on the fetch strobe. During execute, the opcode chooses the datapath routing, and the execute strobe commits the result. A conditional branch commits a new PC only when the accumulator is zero. Phase generation and the datapath itself sit outside this block.

Opcode encoding (3 bits): 0 halt, 1 add, 2 bitwise AND, 3 bitwise XOR, 4 load-address (the address field itself goes into the accumulator), 5 load from memory, 6 store, 7 branch if accumulator is zero.

Top module: `accdec_top`

## Requirements
- R1: With neither phase level high and no strobe, all fifteen output lines are low.
- R2: While the fetch level is high, `addr_sel_pc` and `pc_inc` are high and every other line is low, except that `ir_wr` and `pc_wr` follow the fetch strobe.
- R3: In execute with opcode 1, 2 or 3, `addr_sel_ir`, `acc_sel_alu` and exactly the matching ALU select (`alu_add` for 1, `alu_and` for 2, `alu_xor` for 3) are high, and `acc_wr` follows the execute strobe.
- R4: In execute with opcode 5, `addr_sel_ir` and `acc_sel_mem` are high and `acc_wr` follows the execute strobe.
- R5: In execute with opcode 4, `acc_sel_ir` is high, no address select is high, and `acc_wr` follows the execute strobe.
- R6: In execute with opcode 6, `addr_sel_ir` is high and `mem_wr` follows the execute strobe; no accumulator select is high.
- R7: In execute with opcode 7, `pc_load` and `pc_wr` are high only while the execute strobe is high and the accumulator-zero flag is 1; all other lines are low.
- R8: In execute with opcode 0, `halt` is high for the whole execute level, with every other line low.
- R9: A strobe whose phase level is low has no effect: every write enable stays low.
- R10: If both phase levels are high at once, the outputs are those of fetch.
- R11: Each select group (ALU operation, accumulator input, memory address) has at most one line high.
- R12: The accumulator-zero flag changes no output except under opcode 7 in execute with the execute strobe high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ph_fetch | input | 1 | Fetch phase level |
| stb_fetch | input | 1 | Write strobe inside fetch |
| ph_exec | input | 1 | Execute phase level |
| stb_exec | input | 1 | Write strobe inside execute |
| opcode | input | 3 | Instruction opcode |
| acc_zero | input | 1 | Accumulator equals zero |
| halt | output | 1 | Stop the machine |
| alu_add | output | 1 | ALU performs addition |
| alu_and | output | 1 | ALU performs bitwise AND |
| alu_xor | output | 1 | ALU performs bitwise XOR |
| acc_sel_alu | output | 1 | Accumulator input from ALU |
| acc_sel_mem | output | 1 | Accumulator input from memory |
| acc_sel_ir | output | 1 | Accumulator input from IR address field |
| addr_sel_pc | output | 1 | Memory address from PC |
| addr_sel_ir | output | 1 | Memory address from IR address field |
| ir_wr | output | 1 | Instruction register write |
| acc_wr | output | 1 | Accumulator write |
| mem_wr | output | 1 | Memory write |
| pc_inc | output | 1 | PC source is incrementer |
| pc_load | output | 1 | PC source is IR address field |
| pc_wr | output | 1 | PC write |

## Verification
The bench drives all eight opcodes with the accumulator-zero flag at both values. It does so under seven phase patterns: idle, fetch level alone, fetch with strobe, execute level alone, execute with strobe, strobes with no level, and both levels at once. It compares the complete 15-line vector each time. The level-only and level-plus-strobe patterns separate routing from committing. The strobe-without-level pattern shows that writes are gated by their phase. The two flag values separate the taken branch from the untaken one and show that the flag is ignored elsewhere. The overlapping-phase pattern pins down the fetch priority.

// File: rtl/accdec_pkg.sv
// Package: shared opcode encoding and the control-line bundle for the
// accumulator processor decoder. Assumes a 3-bit opcode space fully used.
package accdec_pkg;
    localparam int OP_W  = 3;
    localparam int N_OPS = 1 << OP_W;

    typedef enum logic [OP_W-1:0] {
        OP_HALT  = 3'd0,
        OP_ADD   = 3'd1,
        OP_AND   = 3'd2,
        OP_XOR   = 3'd3,
        OP_LDA   = 3'd4,
        OP_LOAD  = 3'd5,
        OP_STORE = 3'd6,
        OP_BRZ   = 3'd7
    } op_e;

    typedef struct packed {
        logic halt;
        logic alu_add;
        logic alu_and;
        logic alu_xor;
        logic acc_sel_alu;
        logic acc_sel_mem;
        logic acc_sel_ir;
        logic addr_sel_pc;
        logic addr_sel_ir;
        logic ir_wr;
        logic acc_wr;
        logic mem_wr;
        logic pc_inc;
        logic pc_load;
        logic pc_wr;
    } ctl_lines_t;
endpackage

// File: rtl/accdec_phase_qual.sv
// Module: qualifies the raw phase levels and strobes.
// Fetch wins when both levels are high; a strobe counts only inside
// its own phase level. Assumes the phase generator is otherwise sane.
module accdec_phase_qual (
    input  logic ph_fetch,
    input  logic stb_fetch,
    input  logic ph_exec,
    input  logic stb_exec,
    output logic in_fetch,
    output logic fetch_commit,
    output logic in_exec,
    output logic exec_commit
);
    // Purpose: derive the effective phase and the gated commit pulses.
    always_comb begin
        in_fetch     = ph_fetch;
        fetch_commit = ph_fetch & stb_fetch;
        in_exec      = ph_exec & ~ph_fetch;
        exec_commit  = in_exec & stb_exec;
    end
endmodule

// File: rtl/accdec_op_onehot.sv
// Module: expands the binary opcode into one line per opcode value.
// Assumes the opcode is a known value; exactly one output is high.
module accdec_op_onehot
    import accdec_pkg::*;
#(
    parameter int W = OP_W,
    localparam int N = 1 << W
) (
    input  logic [W-1:0] opcode,
    output logic [N-1:0] op_hot
);
    for (genvar i = 0; i < N; i++) begin : g_hot
        // Purpose: raise line i when the opcode equals i.
        assign op_hot[i] = (opcode == W'(i));
    end
endmodule

// File: rtl/accdec_line_drive.sv
// Module: forms the fifteen control lines from the qualified phase,
// the one-hot opcode and the zero flag. Assumes in_fetch and in_exec
// are never both high (the qualifier guarantees this).
module accdec_line_drive
    import accdec_pkg::*;
(
    input  logic             in_fetch,
    input  logic             fetch_commit,
    input  logic             in_exec,
    input  logic             exec_commit,
    input  logic [N_OPS-1:0] op_hot,
    input  logic             acc_zero,
    output ctl_lines_t       lines
);
    logic is_alu;
    logic writes_acc;
    logic uses_mem_addr;
    logic take_branch;

    // Purpose: group opcodes that share datapath routing.
    assign is_alu        = op_hot[OP_ADD] | op_hot[OP_AND] | op_hot[OP_XOR];
    assign writes_acc    = is_alu | op_hot[OP_LOAD] | op_hot[OP_LDA];
    assign uses_mem_addr = is_alu | op_hot[OP_LOAD] | op_hot[OP_STORE];
    assign take_branch   = exec_commit & op_hot[OP_BRZ] & acc_zero;

    // Purpose: drive every control line for the current phase.
    always_comb begin
        lines = '0;
        if (in_fetch) begin
            lines.addr_sel_pc = 1'b1;
            lines.pc_inc      = 1'b1;
            lines.ir_wr       = fetch_commit;
            lines.pc_wr       = fetch_commit;
        end else if (in_exec) begin
            lines.halt        = op_hot[OP_HALT];
            lines.alu_add     = op_hot[OP_ADD];
            lines.alu_and     = op_hot[OP_AND];
            lines.alu_xor     = op_hot[OP_XOR];
            lines.acc_sel_alu = is_alu;
            lines.acc_sel_mem = op_hot[OP_LOAD];
            lines.acc_sel_ir  = op_hot[OP_LDA];
            lines.addr_sel_ir = uses_mem_addr;
            lines.acc_wr      = exec_commit & writes_acc;
            lines.mem_wr      = exec_commit & op_hot[OP_STORE];
            lines.pc_load     = take_branch;
            lines.pc_wr       = take_branch;
        end
    end
endmodule

// File: rtl/accdec_top.sv
// Module: top of the control-line decoder. Purely combinational.
// Assumes strobes are pulses inside their phase levels; anything else
// is tolerated (gated off, fetch taking priority on overlap).
module accdec_top
    import accdec_pkg::*;
(
    input  logic            ph_fetch,
    input  logic            stb_fetch,
    input  logic            ph_exec,
    input  logic            stb_exec,
    input  logic [OP_W-1:0] opcode,
    input  logic            acc_zero,
    output logic            halt,
    output logic            alu_add,
    output logic            alu_and,
    output logic            alu_xor,
    output logic            acc_sel_alu,
    output logic            acc_sel_mem,
    output logic            acc_sel_ir,
    output logic            addr_sel_pc,
    output logic            addr_sel_ir,
    output logic            ir_wr,
    output logic            acc_wr,
    output logic            mem_wr,
    output logic            pc_inc,
    output logic            pc_load,
    output logic            pc_wr
);
    logic             in_fetch, fetch_commit, in_exec, exec_commit;
    logic [N_OPS-1:0] op_hot;
    ctl_lines_t       lines;

    accdec_phase_qual u_qual (
        .ph_fetch    (ph_fetch),
        .stb_fetch   (stb_fetch),
        .ph_exec     (ph_exec),
        .stb_exec    (stb_exec),
        .in_fetch    (in_fetch),
        .fetch_commit(fetch_commit),
        .in_exec     (in_exec),
        .exec_commit (exec_commit)
    );

    accdec_op_onehot #(.W(OP_W)) u_hot (
        .opcode(opcode),
        .op_hot(op_hot)
    );

    accdec_line_drive u_drive (
        .in_fetch    (in_fetch),
        .fetch_commit(fetch_commit),
        .in_exec     (in_exec),
        .exec_commit (exec_commit),
        .op_hot      (op_hot),
        .acc_zero    (acc_zero),
        .lines       (lines)
    );

    // Purpose: break the bundle out onto the named ports.
    always_comb begin
        halt        = lines.halt;
        alu_add     = lines.alu_add;
        alu_and     = lines.alu_and;
        alu_xor     = lines.alu_xor;
        acc_sel_alu = lines.acc_sel_alu;
        acc_sel_mem = lines.acc_sel_mem;
        acc_sel_ir  = lines.acc_sel_ir;
        addr_sel_pc = lines.addr_sel_pc;
        addr_sel_ir = lines.addr_sel_ir;
        ir_wr       = lines.ir_wr;
        acc_wr      = lines.acc_wr;
        mem_wr      = lines.mem_wr;
        pc_inc      = lines.pc_inc;
        pc_load     = lines.pc_load;
        pc_wr       = lines.pc_wr;
    end

    // Purpose: guard the output contract against the raw port inputs.
    always_comb begin
        a_r11_alu_sel_onehot: assert ($onehot0({lines.alu_add, lines.alu_and, lines.alu_xor}))
            else $error("R11 ALU selects overlap");
        a_r11_acc_sel_onehot: assert ($onehot0({lines.acc_sel_alu, lines.acc_sel_mem, lines.acc_sel_ir}))
            else $error("R11 accumulator selects overlap");
        a_r11_addr_sel_onehot: assert ($onehot0({lines.addr_sel_pc, lines.addr_sel_ir}))
            else $error("R11 address selects overlap");
        a_r9_fetch_wr_in_strobe: assert (!lines.ir_wr || (ph_fetch && stb_fetch))
            else $error("R9 IR write outside fetch strobe");
        a_r9_exec_wr_in_strobe: assert (!(lines.acc_wr || lines.mem_wr) || (ph_exec && stb_exec && !ph_fetch))
            else $error("R9 execute write outside execute strobe");
        a_r7_load_needs_zero: assert (!lines.pc_load || (acc_zero && opcode == OP_BRZ && stb_exec))
            else $error("R7 PC load without taken branch");
        a_r8_halt_in_exec: assert (!lines.halt || (ph_exec && !ph_fetch && opcode == OP_HALT))
            else $error("R8 halt outside execute");
    end
endmodule

// File: tb/accdec_top_bench.sv
`timescale 1ns/1ps
module accdec_top_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic ph_fetch = 0, stb_fetch = 0, ph_exec = 0, stb_exec = 0, acc_zero = 0;
    logic [2:0] opcode = 3'd0;
    logic halt, alu_add, alu_and, alu_xor, acc_sel_alu, acc_sel_mem, acc_sel_ir;
    logic addr_sel_pc, addr_sel_ir, ir_wr, acc_wr, mem_wr, pc_inc, pc_load, pc_wr;

    accdec_top u_accdec_top (
        .ph_fetch(ph_fetch), .stb_fetch(stb_fetch), .ph_exec(ph_exec), .stb_exec(stb_exec),
        .opcode(opcode), .acc_zero(acc_zero),
        .halt(halt), .alu_add(alu_add), .alu_and(alu_and), .alu_xor(alu_xor),
        .acc_sel_alu(acc_sel_alu), .acc_sel_mem(acc_sel_mem), .acc_sel_ir(acc_sel_ir),
        .addr_sel_pc(addr_sel_pc), .addr_sel_ir(addr_sel_ir),
        .ir_wr(ir_wr), .acc_wr(acc_wr), .mem_wr(mem_wr),
        .pc_inc(pc_inc), .pc_load(pc_load), .pc_wr(pc_wr)
    );

    // Bit order: halt add and xor | accALU accMEM accIR | addrPC addrIR | irW accW memW | pcInc pcLoad pcW
    typedef struct {
        logic [14:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];

    int checks = 0, fails = 0;
    bit done = 0;

    function automatic logic [14:0] model(input logic pf, sf, pe, se, input logic [2:0] op, input logic z);
        logic h = 0, ad = 0, an = 0, xo = 0, ca = 0, cm = 0, ci = 0, mp = 0, mi = 0;
        logic iw = 0, aw = 0, mw = 0, pi = 0, pl = 0, pw = 0;
        if (pf) begin                       // R2, R10
            mp = 1; pi = 1; iw = sf; pw = sf;
        end else if (pe) begin
            case (op)
                3'd0: h = 1;                                         // R8
                3'd1: begin ad = 1; ca = 1; mi = 1; aw = se; end     // R3
                3'd2: begin an = 1; ca = 1; mi = 1; aw = se; end     // R3
                3'd3: begin xo = 1; ca = 1; mi = 1; aw = se; end     // R3
                3'd4: begin ci = 1; aw = se; end                     // R5
                3'd5: begin cm = 1; mi = 1; aw = se; end             // R4
                3'd6: begin mi = 1; mw = se; end                     // R6
                default: begin pl = se & z; pw = se & z; end         // R7, R12
            endcase
        end                                   // else R1 / R9: all low
        return {h, ad, an, xo, ca, cm, ci, mp, mi, iw, aw, mw, pi, pl, pw};
    endfunction

    function automatic string tag_of(input logic pf, sf, pe, se, input logic [2:0] op);
        if (pf && pe) return "R10";
        if (pf) return "R2";
        if (!pe) return (sf || se) ? "R9" : "R1";
        case (op)
            3'd0: return "R8";
            3'd1, 3'd2, 3'd3: return "R3";
            3'd4: return "R5";
            3'd5: return "R4";
            3'd6: return "R6";
            default: return "R7";
        endcase
    endfunction

    // Driver: apply inputs just after a rising edge and queue the expectation.
    task automatic drive(input logic pf, sf, pe, se, input logic [2:0] op, input logic z);
        item_t it;
        @(posedge clk);
        #1;
        ph_fetch = pf; stb_fetch = sf; ph_exec = pe; stb_exec = se; opcode = op; acc_zero = z;
        it.exp = model(pf, sf, pe, se, op, z);
        it.tag = tag_of(pf, sf, pe, se, op);
        if (z) it.tag = {it.tag, "/R12"};
        sb_q.push_back(it);
    endtask

    // Monitor: on the falling edge, compare observed lines with the queue head.
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                item_t it;
                logic [14:0] got;
                it = sb_q.pop_front();
                got = {halt, alu_add, alu_and, alu_xor, acc_sel_alu, acc_sel_mem, acc_sel_ir,
                       addr_sel_pc, addr_sel_ir, ir_wr, acc_wr, mem_wr, pc_inc, pc_load, pc_wr};
                checks++;
                if (got !== it.exp) begin
                    fails++;
                    $display("FAIL %s lines got=%015b exp=%015b", it.tag, got, it.exp);
                end
                checks++;
                if (!$onehot0(got[13:11]) || !$onehot0(got[10:8]) || !$onehot0(got[7:6])) begin
                    fails++;
                    $display("FAIL R11 select groups got=%015b exp=at most one per group", got);
                end
            end
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    // Watchdog: an overlong run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog got=timeout exp=completion");
            summary();
            $finish;
        end
    end

    initial begin
        // Reset period: idle inputs, outputs must be all low (R1).
        drive(0, 0, 0, 0, 3'd0, 0);
        drive(0, 0, 0, 0, 3'd7, 1);
        rst_n = 1'b1;
        for (int mode = 0; mode < 7; mode++) begin
            for (int op = 0; op < 8; op++) begin
                for (int z = 0; z < 2; z++) begin
                    case (mode)
                        0: drive(0, 0, 0, 0, 3'(op), 1'(z));   // idle
                        1: drive(1, 0, 0, 0, 3'(op), 1'(z));   // fetch level
                        2: drive(1, 1, 0, 0, 3'(op), 1'(z));   // fetch strobe
                        3: drive(0, 0, 1, 0, 3'(op), 1'(z));   // execute level
                        4: drive(0, 0, 1, 1, 3'(op), 1'(z));   // execute strobe
                        5: drive(0, 1, 0, 1, 3'(op), 1'(z));   // strobes, no level
                        default: drive(1, 1, 1, 1, 3'(op), 1'(z)); // overlap
                    endcase
                end
            end
        end
        while (sb_q.size() > 0) @(posedge clk);
        @(posedge clk);
        done = 1;
        summary();
        $finish;
    end
endmodule